// File: doc/BRIEF.md
# Selectable Zero-Substitution Line Encoder

This block is the per-channel transmit encoder of a line interface. It accepts single-rail NRZ data, one bit per strobe of a bit-clock enable, and produces a positive rail and a negative rail, each held for one bit period. At run time it can apply plain alternate mark inversion (AMI), HDB3 zero substitution for the 2.048 Mbit/s standard, or B8ZS substitution for the 1.544 Mbit/s standard.

There are three other sources for the output pair. A dual-rail mode bypasses the coder and passes externally supplied rails through. A transmit-all-ones request replaces the data with a continuous alternating-mark pattern. A remote-loopback request passes received rails back to the line and overrides the all-ones request. Every source goes through the same delay line. Latency is therefore identical in all modes, and the coder sees a whole zero run before it emits the first bit of that run.

The block runs on a free-running master clock. If the bit strobe stops while all-ones is being sent, the pattern continues at a rate derived from the master clock.

Top module: `zs_line_encoder`

## Requirements
- R1: After a synchronous reset both rails are low. The first mark sent afterwards is positive (`tx_pos`=1). The violation parity starts even, so the first HDB3 substitution after reset has the form B00V.
- R2: Each input bit appears on the rails exactly DEPTH (default 8) bit strobes after the strobe that loaded it. The latency is the same in every mode.
- R3: With `ami_only`=1, each 1 becomes a mark of the opposite polarity to the previous mark, and each 0 becomes no pulse. No zero substitution is applied.
- R4: With `ami_only`=0 and `std_t1`=0, each run of four zeros is replaced. If an even number of marks has been sent since the last violation, the replacement is B00V; if the number is odd, it is 000V. B follows the alternation rule. V has the polarity of the mark just before it.
- R5: With `ami_only`=0 and `std_t1`=1, each run of eight zeros is replaced by 000VB0VB, with polarities taken relative to the last mark before the run. The polarity state afterwards is the same as before the run.
- R6: With `dual_rail`=1, `ext_pos` and `ext_neg` reach the rails uncoded. An input pair of 1,1 is sent as 0,0.
- R7: With `all_ones`=1, the data inputs are ignored and every bit is a mark of alternating polarity.
- R8: With `loop_en`=1, `lb_pos` and `lb_neg` reach the rails (1,1 sent as 0,0). This applies even when `all_ones` or any coding mode is also selected.
- R9: `tx_pos` and `tx_neg` are never both high.
- R10: The rails change only on a bit advance. With no bit strobe they hold their value, unless R11 applies.
- R11: If `all_ones`=1, `loop_en`=0 and no bit strobe has arrived for STALL_LIM master-clock cycles, the block advances one bit every REF_DIV master-clock cycles. Each of these bits is an alternating mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit bit strobe, one master-clock cycle per bit |
| nrz_in | input | 1 | Single-rail NRZ data |
| ext_pos | input | 1 | External positive rail for dual-rail mode |
| ext_neg | input | 1 | External negative rail for dual-rail mode |
| lb_pos | input | 1 | Received positive rail for remote loopback |
| lb_neg | input | 1 | Received negative rail for remote loopback |
| dual_rail | input | 1 | 1 selects coder bypass with external rails |
| ami_only | input | 1 | 1 selects plain AMI, 0 selects zero substitution |
| std_t1 | input | 1 | 1 selects B8ZS, 0 selects HDB3 |
| all_ones | input | 1 | Transmit-all-ones request |
| loop_en | input | 1 | Remote-loopback request, overrides all_ones |
| tx_pos | output | 1 | Positive pulse rail |
| tx_neg | output | 1 | Negative pulse rail |

## Verification
The assertions check four properties on every cycle:
- the rails are never both high;
- the rails hold between bit advances;
- a fallback advance happens only when all-ones is active without loopback;
- a fallback advance happens only after a full stall window with no strobe.

The choice between B00V and 000V, the polarity of the substitution pulses, the fixed latency, the passthrough cleaning and the source priority all depend on the history of the data. Only the scoreboard shows these: it compares every emitted bit with a model that sees the whole input sequence.

// File: rtl/zs_enc_pkg.sv
`timescale 1ns/1ps
package zs_enc_pkg;

  localparam int WIN_E1 = 4;
  localparam int WIN_T1 = 8;
  localparam int POS_W  = 3;

  typedef enum logic [1:0] {
    SRC_RAW   = 2'd0,
    SRC_CODED = 2'd1,
    SRC_ONES  = 2'd2
  } src_e;

  typedef struct packed {
    src_e src;
    logic dat;
    logic rp;
    logic rn;
  } slot_t;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_RAW  = 2'd3
  } sym_e;

  localparam slot_t SLOT_IDLE = '{src: SRC_RAW, dat: 1'b0, rp: 1'b0, rn: 1'b0};

  // Symbol at a given position of a substitution pattern.
  function automatic sym_e sub_symbol(input logic t1, input logic lead_b,
                                      input logic [POS_W-1:0] pos);
    sym_e s;
    s = SYM_ZERO;
    if (t1) begin
      case (pos)
        3'd3, 3'd6: s = SYM_VIOL;
        3'd4, 3'd7: s = SYM_MARK;
        default:    s = SYM_ZERO;
      endcase
    end else begin
      if (pos == 3'd3)                 s = SYM_VIOL;
      else if (pos == 3'd0 && lead_b)  s = SYM_MARK;
    end
    return s;
  endfunction

endpackage

// File: rtl/zs_strobe_gen.sv
`timescale 1ns/1ps
module zs_strobe_gen #(
  parameter int STALL_LIM = 330,
  parameter int REF_DIV   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic fb_allow,
  output logic adv
);
  localparam int SW = $clog2(STALL_LIM + 1);
  localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic [SW-1:0] idle_cnt;
  logic [RW-1:0] ref_cnt;
  logic          stalled;
  logic          ref_tick;

  assign stalled  = (idle_cnt == SW'(STALL_LIM));
  assign ref_tick = (ref_cnt == RW'(REF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || bit_en)
      idle_cnt <= '0;
    else if (!stalled)
      idle_cnt <= idle_cnt + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || ref_tick)
      ref_cnt <= '0;
    else
      ref_cnt <= ref_cnt + RW'(1);
  end

  assign adv = bit_en | (fb_allow & stalled & ref_tick);

endmodule

// File: rtl/zs_delay_line.sv
`timescale 1ns/1ps
module zs_delay_line
  import zs_enc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  slot_t                  din,
  output slot_t [DEPTH-1:0]      taps
);
  slot_t stg [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      slot_t nxt;
      if (g == DEPTH - 1) begin : g_entry
        assign nxt = din;
      end else begin : g_shift
        assign nxt = stg[g+1];
      end
      always_ff @(posedge clk) begin
        if (rst)
          stg[g] <= SLOT_IDLE;
        else if (adv)
          stg[g] <= nxt;
      end
      assign taps[g] = stg[g];
    end
  endgenerate

endmodule

// File: rtl/zs_sub_head.sv
`timescale 1ns/1ps
module zs_sub_head
  import zs_enc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  slot_t [DEPTH-1:0] taps,
  input  logic              ami_only,
  input  logic              std_t1,
  output logic              tx_pos,
  output logic              tx_neg
);
  slot_t            head;
  logic [DEPTH-1:0] zero_w;
  logic             run_ok;
  logic             start;
  sym_e             sym;

  logic             sub_act;
  logic             sub_t1;
  logic             sub_b00v;
  logic [POS_W-1:0] sub_pos;
  logic [POS_W-1:0] sub_last;
  logic             last_pol;  // 1: last mark was positive
  logic             parity;    // marks since last violation, mod 2

  assign head = taps[0];

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      zero_w[i] = (taps[i].src == SRC_CODED) && !taps[i].dat;
  end

  assign run_ok   = std_t1 ? (&zero_w[WIN_T1-1:0]) : (&zero_w[WIN_E1-1:0]);
  assign start    = !sub_act && !ami_only && run_ok;
  assign sub_last = sub_t1 ? POS_W'(WIN_T1 - 1) : POS_W'(WIN_E1 - 1);

  always_comb begin
    if (sub_act)
      sym = sub_symbol(sub_t1, sub_b00v, sub_pos);
    else if (start)
      sym = sub_symbol(std_t1, !parity, '0);
    else begin
      case (head.src)
        SRC_CODED: sym = head.dat ? SYM_MARK : SYM_ZERO;
        SRC_ONES:  sym = SYM_MARK;
        default:   sym = SYM_RAW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_act  <= 1'b0;
      sub_t1   <= 1'b0;
      sub_b00v <= 1'b0;
      sub_pos  <= '0;
    end else if (adv) begin
      if (sub_act) begin
        if (sub_pos == sub_last)
          sub_act <= 1'b0;
        else
          sub_pos <= sub_pos + POS_W'(1);
      end else if (start) begin
        sub_act  <= 1'b1;
        sub_pos  <= POS_W'(1);
        sub_t1   <= std_t1;
        sub_b00v <= !parity;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pos   <= 1'b0;
      tx_neg   <= 1'b0;
      last_pol <= 1'b0;
      parity   <= 1'b0;
    end else if (adv) begin
      case (sym)
        SYM_MARK: begin
          tx_pos   <= !last_pol;
          tx_neg   <= last_pol;
          last_pol <= !last_pol;
          parity   <= !parity;
        end
        SYM_VIOL: begin
          tx_pos <= last_pol;
          tx_neg <= !last_pol;
          parity <= 1'b0;
        end
        SYM_RAW: begin
          tx_pos <= head.rp & !head.rn;
          tx_neg <= head.rn & !head.rp;
        end
        default: begin
          tx_pos <= 1'b0;
          tx_neg <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/zs_line_encoder.sv
`timescale 1ns/1ps
module zs_line_encoder
  import zs_enc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int STALL_LIM = 330,
  parameter int REF_DIV   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic nrz_in,
  input  logic ext_pos,
  input  logic ext_neg,
  input  logic lb_pos,
  input  logic lb_neg,
  input  logic dual_rail,
  input  logic ami_only,
  input  logic std_t1,
  input  logic all_ones,
  input  logic loop_en,
  output logic tx_pos,
  output logic tx_neg
);
  slot_t             in_slot;
  slot_t [DEPTH-1:0] taps;
  logic              adv;
  logic              fb_allow;

  assign fb_allow = all_ones & !loop_en;

  // Source priority: loopback, then all-ones, then dual-rail, then coder.
  always_comb begin
    in_slot = SLOT_IDLE;
    if (loop_en) begin
      in_slot.rp = lb_pos;
      in_slot.rn = lb_neg;
    end else if (all_ones) begin
      in_slot.src = SRC_ONES;
    end else if (dual_rail) begin
      in_slot.rp = ext_pos;
      in_slot.rn = ext_neg;
    end else begin
      in_slot.src = SRC_CODED;
      in_slot.dat = nrz_in;
    end
  end

  zs_strobe_gen #(.STALL_LIM(STALL_LIM), .REF_DIV(REF_DIV)) u_strobe (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fb_allow(fb_allow), .adv(adv)
  );

  zs_delay_line #(.DEPTH(DEPTH)) u_delay (
    .clk(clk), .rst(rst), .adv(adv), .din(in_slot), .taps(taps)
  );

  zs_sub_head #(.DEPTH(DEPTH)) u_head (
    .clk(clk), .rst(rst), .adv(adv), .taps(taps),
    .ami_only(ami_only), .std_t1(std_t1),
    .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

endmodule

// File: rtl/zs_line_encoder_chk.sv
`timescale 1ns/1ps
module zs_line_encoder_chk #(
  parameter int STALL_LIM = 330
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic all_ones,
  input logic loop_en,
  input logic adv,
  input logic tx_pos,
  input logic tx_neg
);
  localparam int CW = $clog2(STALL_LIM + 1);
  logic [CW-1:0] since_bit;

  always_ff @(posedge clk) begin
    if (rst || bit_en)
      since_bit <= '0;
    else if (since_bit != CW'(STALL_LIM))
      since_bit <= since_bit + CW'(1);
  end

  // R9
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_pos && tx_neg));

  // R10
  rails_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(tx_pos) && $stable(tx_neg)));

  // R11
  fallback_source_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !bit_en) |-> (all_ones && !loop_en));

  // R11
  fallback_window_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !bit_en) |-> (since_bit == CW'(STALL_LIM)));

endmodule

bind zs_line_encoder zs_line_encoder_chk #(.STALL_LIM(STALL_LIM)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .all_ones(all_ones),
  .loop_en(loop_en), .adv(adv), .tx_pos(tx_pos), .tx_neg(tx_neg)
);

// File: tb/test_zs_line_encoder.sv
`timescale 1ns/1ps
module test_zs_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int STALL_LIM  = 20;
  localparam int REF_DIV    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, nrz_in = 1'b0;
  logic ext_pos = 1'b0, ext_neg = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
  logic dual_rail = 1'b0, ami_only = 1'b0, std_t1 = 1'b0;
  logic all_ones = 1'b0, loop_en = 1'b0;
  logic tx_pos, tx_neg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic mon_go = 1'b0;
  string cur_req = "R2";
  logic [1:0] exp_q[$];
  bit d_v [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  zs_line_encoder #(.DEPTH(DEPTH), .STALL_LIM(STALL_LIM), .REF_DIV(REF_DIV)) i_zs_line_encoder (
    .clk(clk), .rst(rst), .bit_en(bit_en), .nrz_in(nrz_in),
    .ext_pos(ext_pos), .ext_neg(ext_neg), .lb_pos(lb_pos), .lb_neg(lb_neg),
    .dual_rail(dual_rail), .ami_only(ami_only), .std_t1(std_t1),
    .all_ones(all_ones), .loop_en(loop_en), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic chk_int(string req, int got, int lo, int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d..%0d", req, got, lo, hi);
    end
  endtask

  // Monitor: pops one expected pair per strobe.
  always @(posedge clk) mon_go <= bit_en & ~rst;

  always @(negedge clk) begin
    if (mon_go) begin
      chk("R9", {1'b0, tx_pos & tx_neg}, 2'b00);
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s got=%b exp=none", cur_req, {tx_pos, tx_neg});
      end else begin
        chk(cur_req, {tx_pos, tx_neg}, exp_q.pop_front());
      end
    end
  end

  // Model state for polarity and violation parity.
  logic m_last;
  logic m_par;

  task automatic m_mark();
    m_last = ~m_last;
    exp_q.push_back({m_last, ~m_last});
    m_par = ~m_par;
  endtask

  task automatic m_viol();
    exp_q.push_back({m_last, ~m_last});
    m_par = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    m_last = 1'b0;
    m_par  = 1'b0;
    rst = 1'b0;
  endtask

  task automatic strobe(logic d, logic ep, logic en, logic lp, logic ln);
    @(negedge clk);
    nrz_in = d; ext_pos = ep; ext_neg = en; lb_pos = lp; lb_neg = ln;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic gen_data(int n, int lead);
    int idx = 0;
    for (int i = 0; i < lead && idx < n; i++) d_v[idx++] = 1'b0;
    while (idx < n) begin
      int z;
      d_v[idx++] = 1'b1;
      z = $urandom % 11;
      for (int k = 0; k < z && idx < n; k++) d_v[idx++] = 1'b0;
    end
  endtask

  task automatic model_coded(int n, bit ami, bit t1);
    int i = 0;
    int len;
    len = t1 ? 8 : 4;
    while (i < n) begin
      bit allz;
      allz = !ami && (i + len <= n);
      for (int k = 0; k < len && allz; k++) if (d_v[i+k]) allz = 1'b0;
      if (allz) begin
        for (int k = 0; k < len; k++) begin
          if (t1) begin
            if (k == 3 || k == 6)      m_viol();
            else if (k == 4 || k == 7) m_mark();
            else                       exp_q.push_back(2'b00);
          end else begin
            if (k == 3)                     m_viol();
            else if (k == 0 && m_par == 0)  m_mark();
            else                            exp_q.push_back(2'b00);
          end
        end
        i += len;
      end else begin
        if (d_v[i]) m_mark();
        else        exp_q.push_back(2'b00);
        i++;
      end
    end
  endtask

  task automatic run_coded(int n, bit ami, bit t1, int lead, string req);
    do_reset();
    dual_rail = 1'b0; all_ones = 1'b0; loop_en = 1'b0;
    ami_only = ami; std_t1 = t1;
    cur_req = req;
    gen_data(n, lead);
    repeat (DEPTH) exp_q.push_back(2'b00);
    model_coded(n, ami, t1);
    for (int i = 0; i < n; i++) strobe(d_v[i], 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // mode: 0 dual-rail, 1 all-ones, 2 loopback with all-ones also set
  task automatic run_src(int n, int mode, string req);
    do_reset();
    ami_only = 1'b0; std_t1 = 1'b0;
    dual_rail = (mode == 0);
    all_ones  = (mode != 0);
    loop_en   = (mode == 2);
    cur_req = req;
    repeat (DEPTH) exp_q.push_back(2'b00);
    for (int i = 0; i < n; i++) begin
      logic d, ep, en, lp, ln;
      d = 1'($urandom); ep = 1'($urandom); en = 1'($urandom);
      lp = 1'($urandom); ln = 1'($urandom);
      if (i < 4) begin ep = 1'b1; en = 1'b1; lp = 1'b1; ln = 1'b1; end
      if (mode == 0)      exp_q.push_back({ep & ~en, en & ~ep});
      else if (mode == 1) m_mark();
      else                exp_q.push_back({lp & ~ln, ln & ~lp});
      strobe(d, ep, en, lp, ln);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", {tx_pos, tx_neg}, 2'b00);

    run_coded(120, 1'b1, 1'b0, 0, "R2/R3");
    run_coded(120, 1'b1, 1'b1, 3, "R3");

    // R10: stalled strobe outside all-ones leaves the rails untouched
    begin
      logic [1:0] held;
      int chg = 0;
      held = {tx_pos, tx_neg};
      repeat (100) begin
        @(negedge clk);
        if ({tx_pos, tx_neg} !== held) chg++;
      end
      chk_int("R10", chg, 0, 0);
    end

    run_coded(160, 1'b0, 1'b0, 5, "R1/R4");
    run_coded(160, 1'b0, 1'b0, 0, "R4");
    run_coded(160, 1'b0, 1'b1, 9, "R5");
    run_coded(160, 1'b0, 1'b1, 0, "R5");
    run_src(40, 0, "R6");
    run_src(40, 2, "R8");
    run_src(24, 1, "R7");

    // R11: all-ones continues from the reference once strobes stop
    begin
      logic [1:0] prev;
      int chg = 0;
      int bad = 0;
      repeat (30) @(negedge clk);
      prev = {tx_pos, tx_neg};
      repeat (20 * REF_DIV) begin
        @(negedge clk);
        if ({tx_pos, tx_neg} !== prev) begin
          chg++;
          if (!(({tx_pos, tx_neg} == 2'b10) || ({tx_pos, tx_neg} == 2'b01))) bad++;
          prev = {tx_pos, tx_neg};
        end
      end
      chk_int("R11", chg, 19, 21);
      chk_int("R11", bad, 0, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule